// File: doc/BRIEF.md
# Clocked Ripple Three-State Magnitude Comparator

This block decides whether a captured data word X is greater than, equal to or less than a programmed word A. A row of identical per-bit stages forms the decision. Each stage looks at its own bit pair and at the verdict passed down from the next more significant stage. An unequal verdict from above always wins. The least significant stage gives the final verdict.

A single request pulse starts a fixed internal sequence. First the X register is cleared. Then it loads from the input bus. The block waits a programmable number of settle cycles that covers the worst-case ripple through the chain. Finally it strobes the verdict into three one-hot flags. The A word is either followed live from its port or, when a parameter selects it, captured alongside X at the load step. Requests that arrive while a sequence is running are dropped. The flags keep their value from one strobe to the next.

Top module: `ripple_cmp`

## Requirements
- R1: While reset is held and after it is released, `gt`, `eq`, `lt` and `stb` are all 0 until the first strobe.
- R2: At a strobe, `gt` is 1 exactly when the captured X, read as an unsigned integer, exceeds A.
- R3: At a strobe, `eq` is 1 exactly when the captured X equals A, whatever the common bit pattern is (all zeros and all ones included).
- R4: At a strobe, `lt` is 1 exactly when the captured X is below A.
- R5: The verdict is set by the most significant differing bit pair alone: bit value 1 in X against 0 in A gives greater, 0 against 1 gives less, and every lower bit pair has no effect.
- R6: Counting the rising edge that first samples `req` high as edge 1, `stb` rises after edge SETTLE+3.
- R7: `stb` is high for one cycle only. While it is high exactly one of `gt`, `eq`, `lt` is 1. Between strobes the three flags do not change.
- R8: A `req` that is high while a sequence is running starts no second sequence, and it produces no extra strobe.
- R9: With the A register selected (`A_REG`=1), A is captured on the same edge as X. A change on `a_word` after that edge does not alter the verdict.
- R10: X is captured on edge 3 of the sequence (edge 2 clears it). A change on `x_bus` after edge 3 does not alter the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request to start a compare sequence |
| x_bus | input | W | Data word, loaded into the X register |
| a_word | input | W | Programmed word |
| gt | output | 1 | Verdict flag: X greater than A |
| eq | output | 1 | Verdict flag: X equal to A |
| lt | output | 1 | Verdict flag: X less than A |
| stb | output | 1 | One-cycle pulse when the flags take a new verdict |

## Verification
A four-bit instance is swept over all 256 pairs of X and A. This pins down the verdict for every ordering and separates a correct cascade from one that lets a lower stage override a higher one, or that reads the wrong end of the chain. On a twenty-bit instance, pairs that differ only in the top bit with all lower bits opposed, and pairs that differ only in the bottom bit, show the full ripple length in both directions. Equal words of all zeros and all ones show that no stage invents an inequality. Changing the inputs and pulsing `req` while a sequence is waiting separates the captured-word behaviour and the dropping of requests from a design that follows its inputs live or restarts.

// File: rtl/ripple_cmp.sv
module ripple_cmp #(
  parameter int W      = 20,
  parameter int SETTLE = W,
  parameter bit A_REG  = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [W-1:0] x_bus,
  input  logic [W-1:0] a_word,
  output logic         gt,
  output logic         eq,
  output logic         lt,
  output logic         stb
);
  localparam int CW = (SETTLE < 2) ? 1 : $clog2(SETTLE);

  typedef enum logic [1:0] {S_IDLE, S_CLR, S_SET, S_WAIT} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [W-1:0]  x_q;
  logic [W-1:0]  a_use;
  logic [W:0]    cg, cl;

  // per-bit stages: verdict enters from the MSB side, leaves at bit 0
  assign cg[W] = 1'b0;
  assign cl[W] = 1'b0;
  for (genvar i = W - 1; i >= 0; i--) begin : g_stage
    assign cg[i] = cg[i+1] | (~cl[i+1] &  x_q[i] & ~a_use[i]);
    assign cl[i] = cl[i+1] | (~cg[i+1] & ~x_q[i] &  a_use[i]);
  end

  if (A_REG) begin : g_areg
    always_ff @(posedge clk)
      if (!rst_n)           a_use <= '0;
      else if (st == S_SET) a_use <= a_word;
  end else begin : g_alive
    assign a_use = a_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      x_q <= '0;
      gt  <= 1'b0;
      eq  <= 1'b0;
      lt  <= 1'b0;
      stb <= 1'b0;
    end else begin
      stb <= 1'b0;
      case (st)
        S_IDLE: if (req) st <= S_CLR;
        S_CLR: begin
          x_q <= '0;
          st  <= S_SET;
        end
        S_SET: begin
          x_q <= x_bus;
          cnt <= '0;
          st  <= S_WAIT;
        end
        default: begin
          if (cnt == CW'(SETTLE - 1)) begin
            gt  <= cg[0];
            lt  <= cl[0];
            eq  <= ~(cg[0] | cl[0]);
            stb <= 1'b1;
            st  <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ripple_cmp_chk.sv
module ripple_cmp_chk #(
  parameter int W = 20
) (
  input logic         clk,
  input logic         rst_n,
  input logic         stb,
  input logic         gt,
  input logic         eq,
  input logic         lt,
  input logic [W-1:0] x_q,
  input logic [W-1:0] a_use
);
  // R7
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) stb |=> !stb);
  // R7
  flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) stb |-> $onehot({gt, eq, lt}));
  // R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !stb |-> $stable({gt, eq, lt}));
  // R2
  gt_match_chk: assert property (@(posedge clk) disable iff (!rst_n) stb |-> (gt == $past(x_q > a_use)));
  // R3
  eq_match_chk: assert property (@(posedge clk) disable iff (!rst_n) stb |-> (eq == $past(x_q == a_use)));
  // R4
  lt_match_chk: assert property (@(posedge clk) disable iff (!rst_n) stb |-> (lt == $past(x_q < a_use)));
endmodule

bind ripple_cmp ripple_cmp_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stb(stb), .gt(gt), .eq(eq), .lt(lt),
  .x_q(x_q), .a_use(a_use)
);

// File: tb/sim_ripple_cmp.sv
module sim_ripple_cmp;
  localparam int W0 = 4,  S0 = 4;
  localparam int W1 = 20, S1 = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req0 = 1'b0, req1 = 1'b0;
  logic [W0-1:0] x0 = '0, a0 = '0;
  logic [W1-1:0] x1 = '0, a1 = '0;
  logic gt0, eq0, lt0, stb0, gt1, eq1, lt1, stb1;

  int tests = 0, fails = 0, cyc = 0;

  ripple_cmp #(.W(W0), .SETTLE(S0), .A_REG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req0), .x_bus(x0), .a_word(a0),
    .gt(gt0), .eq(eq0), .lt(lt0), .stb(stb0));

  ripple_cmp #(.W(W1), .SETTLE(S1), .A_REG(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .req(req1), .x_bus(x1), .a_word(a1),
    .gt(gt1), .eq(eq1), .lt(lt1), .stb(stb1));

  task automatic chk(input string rq, input logic [3:0] act, input logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", rq, act, exp);
    end
  endtask

  function automatic logic [2:0] verdict(input longint x, input longint a);
    return {x > a, x == a, x < a};
  endfunction

  // start a sequence on u0; returns negedges from request sample to strobe
  task automatic run0(input logic [W0-1:0] x, input logic [W0-1:0] a, output int n);
    @(negedge clk); x0 = x; a0 = a; req0 = 1'b1;
    @(negedge clk); req0 = 1'b0;
    n = 0;
    while (!stb0 && n < 100) begin @(negedge clk); n++; end
  endtask

  task automatic run1(input logic [W1-1:0] x, input logic [W1-1:0] a, input string rq);
    int n;
    @(negedge clk); x1 = x; a1 = a; req1 = 1'b1;
    @(negedge clk); req1 = 1'b0;
    n = 0;
    while (!stb1 && n < 100) begin @(negedge clk); n++; end
    chk("R6 latency W=20", 4'(n), 4'(S1 + 2));
    chk(rq, {1'b0, gt1, eq1, lt1}, {1'b0, verdict(x, a)});
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected<=150000", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    int n;
    logic [2:0] held;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 reset u0", {gt0, eq0, lt0, stb0}, 4'b0000);
    chk("R1 reset u1", {gt1, eq1, lt1, stb1}, 4'b0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release", {gt0, eq0, lt0, stb0}, 4'b0000);

    // R2 R3 R4 R5 R6: exhaustive sweep of the 4-bit instance
    for (int x = 0; x < 16; x++) begin
      for (int a = 0; a < 16; a++) begin
        run0(4'(x), 4'(a), n);
        chk("R6 latency W=4", 4'(n), 4'(S0 + 2));
        chk(x > a ? "R2 gt sweep" : (x == a ? "R3 eq sweep" : "R4 lt sweep"),
            {1'b0, gt0, eq0, lt0}, {1'b0, verdict(x, a)});
        @(negedge clk);
        chk("R7 one-cycle strobe", {3'b000, stb0}, 4'b0000);
      end
    end

    // R7: flags held across idle time with changed inputs
    run0(4'd9, 4'd3, n);
    held = {gt0, eq0, lt0};
    x0 = 4'd0; a0 = 4'd15;
    repeat (12) @(negedge clk);
    chk("R7 flags hold", {1'b0, gt0, eq0, lt0}, {1'b0, held});

    // R10 and R9: inputs changed after the load edge are not seen
    @(negedge clk); x0 = 4'd2; a0 = 4'd11; req0 = 1'b1;
    @(negedge clk); req0 = 1'b0;
    repeat (3) @(negedge clk);
    x0 = 4'd15; a0 = 4'd0;
    n = 3;
    while (!stb0 && n < 100) begin @(negedge clk); n++; end
    chk("R10 R9 late input change", {1'b0, gt0, eq0, lt0}, 4'b0001);

    // R8: request during a running sequence is dropped
    @(negedge clk); x0 = 4'd7; a0 = 4'd7; req0 = 1'b1;
    @(negedge clk); req0 = 1'b0;
    repeat (3) @(negedge clk);
    x0 = 4'd12; a0 = 4'd1; req0 = 1'b1;
    @(negedge clk); req0 = 1'b0;
    n = 4;
    while (!stb0 && n < 100) begin @(negedge clk); n++; end
    chk("R8 verdict from first request", {1'b0, gt0, eq0, lt0}, 4'b0010);
    n = 0;
    repeat (S0 + 8) begin @(negedge clk); if (stb0) n++; end
    chk("R8 no second strobe", 4'(n), 4'd0);
    chk("R8 flags unchanged", {1'b0, gt0, eq0, lt0}, 4'b0010);

    // corners on the 20-bit instance
    run1('0, '0, "R3 all zeros equal");
    run1('1, '1, "R3 all ones equal");
    run1(20'h80000, 20'h7FFFF, "R5 top bit decides greater");
    run1(20'h7FFFF, 20'h80000, "R5 top bit decides less");
    run1(20'hA5A5B, 20'hA5A5A, "R2 bottom bit greater");
    run1(20'hA5A5A, 20'hA5A5B, "R4 bottom bit less");
    run1(20'h40000, 20'h3FFFF, "R5 second bit over ones");
    run1(20'h12345, 20'h12345, "R3 mixed equal");
    run1(20'h5FFFF, 20'hA0000, "R4 lower ones lose");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule